// File: doc/BRIEF.md
# Modem Handshake Control and Status Register

This block sits beside a serial port and owns the handshake lines to a modem. A host write to the control register drives four active-low outputs: terminal-ready, request-to-send and two general-purpose outputs. A fifth control bit selects a loop mode in which all four outputs are forced inactive (high). The stored control bits are kept while loop mode is on and take effect again when it is cleared.

The block also builds an 8-bit status word from four active-low inputs: clear-to-send, set-ready, ring and carrier. Each input passes through a two-flop synchroniser. The upper nibble of the status word shows the present, synchronised state of the inputs as active-high bits. The lower nibble holds one sticky change flag per input. The ring flag records only the release of a ring, where the pin goes from low to high. The flags stay set until the host reads the status word. A change that arrives in the same cycle as that read is kept for the next read.

The interrupt request is raised while the enable input is high and at least one flag is set. Bus decoding and interrupt priority belong to the surrounding port.

Each input channel runs a two-state flag machine. The states are `DLT_CLEAR` and `DLT_SET`, and the transitions are:
- CLEAR→SET when a change is seen.
- SET→CLEAR when the status is read and no new change is seen.
- SET→SET when a read and a new change happen in the same cycle.

The control path runs a two-state mode machine. The states are `CTL_NORMAL` and `CTL_LOOP`. NORMAL→LOOP happens on a write with bit 4 set, and LOOP→NORMAL on a write with bit 4 clear.

Top module: `modem_hs_regs`

## Requirements
- R1: A control write with bit 0 set drives `dtr_n` low, and bit 1 set drives `rts_n` low. A clear bit drives its pin high. The pins change on the clock edge that takes the write.
- R2: Control bit 2 drives `out1_n` and control bit 3 drives `out2_n`, both active low, with the same timing as R1.
- R3: While `mreset` is high, the control register and the loop mode are cleared, all four outputs are high, all change flags are cleared and `ms_irq` is low.
- R4: Control bit 4 selects loop mode. In loop mode all four outputs are high. The stored bits 0 to 3 are restored to the pins when bit 4 is written back to 0.
- R5: Status bits 4, 5, 6 and 7 are the complement of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. Each bit follows its pin on the second clock edge after the pin changes.
- R6: Status bits 0, 1 and 3 are set on any change of `cts_n`, `dsr_n` and `dcd_n` respectively. The flag becomes visible after the third clock edge following the change.
- R7: Status bit 2 is set only when `ri_n` goes from low to high. A high-to-low change of `ri_n` leaves it clear.
- R8: A set flag holds until a status read (`sts_re` high for one cycle). During that cycle `sts_rdata` still shows the flag. The clock edge that ends the read clears bits 0 to 3.
- R9: A change whose detection falls in the same cycle as a status read sets (or keeps) its flag, so the next read reports it.
- R10: `ms_irq` is high exactly when `ms_irq_en` is high and at least one of status bits 0 to 3 is set.
- R11: `ctl_rdata` returns the stored control bits 4 to 0, with bits 7 to 5 read as 0. Written bits 7 to 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mreset | input | 1 | Master reset, active high, asynchronous |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bits 7:5 ignored) |
| ctl_rdata | output | 8 | Control register read-back |
| sts_re | input | 1 | Status read strobe; clears the change flags |
| sts_rdata | output | 8 | Status word: {ring/carrier/ready/clear levels, change flags} |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| ms_irq | output | 1 | Modem-status interrupt request |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |

## Verification
The assertions assume the following about the inputs:
- `sts_re` and `ctl_we` are clean single-cycle strobes.
- `mreset` is high at time zero.
- Every pin change stays stable long enough to cross the synchroniser, at least three clock edges.

The bench drives all inputs on the falling clock edge and holds each pin level for four or more cycles, except in the test that deliberately times a change to coincide with a status read. Before each master reset the bench returns the pins to their inactive level, so that leaving reset causes no flag.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int HS_LINES   = 4;
    localparam int HS_DATA_W  = 8;
    localparam int CTL_DTR    = 0;
    localparam int CTL_RTS    = 1;
    localparam int CTL_OUT1   = 2;
    localparam int CTL_OUT2   = 3;
    localparam int CTL_LOOP_B = 4;
    localparam int CTL_W      = 5;
    localparam int LINE_RI    = 2;

    typedef enum logic {
        CTL_NORMAL = 1'b0,
        CTL_LOOP   = 1'b1
    } ctl_mode_e;

    typedef enum logic {
        DLT_CLEAR = 1'b0,
        DLT_SET   = 1'b1
    } dlt_state_e;
endpackage

// File: rtl/hs_ctrl_reg.sv
module hs_ctrl_reg
    import hs_pkg::*;
#(
    parameter int DATA_W = HS_DATA_W
) (
    input  logic              clk,
    input  logic              mreset,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n
);
    localparam int PAD_W = DATA_W - CTL_W;

    ctl_mode_e  mode_q, mode_d;
    logic [3:0] bits_q;

    // mode state register
    always_ff @(posedge clk or posedge mreset) begin
        if (mreset) mode_q <= CTL_NORMAL;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            CTL_NORMAL: if (ctl_we && ctl_wdata[CTL_LOOP_B])  mode_d = CTL_LOOP;
            CTL_LOOP:   if (ctl_we && !ctl_wdata[CTL_LOOP_B]) mode_d = CTL_NORMAL;
            default:    mode_d = CTL_NORMAL;
        endcase
    end

    // stored handshake bits
    always_ff @(posedge clk or posedge mreset) begin
        if (mreset)      bits_q <= '0;
        else if (ctl_we) bits_q <= ctl_wdata[3:0];
    end

    // outputs
    always_comb begin
        dtr_n  = 1'b1;
        rts_n  = 1'b1;
        out1_n = 1'b1;
        out2_n = 1'b1;
        unique case (mode_q)
            CTL_NORMAL: begin
                dtr_n  = ~bits_q[CTL_DTR];
                rts_n  = ~bits_q[CTL_RTS];
                out1_n = ~bits_q[CTL_OUT1];
                out2_n = ~bits_q[CTL_OUT2];
            end
            CTL_LOOP: begin
                dtr_n  = 1'b1;
                rts_n  = 1'b1;
                out1_n = 1'b1;
                out2_n = 1'b1;
            end
            default: ;
        endcase
        ctl_rdata = {{PAD_W{1'b0}}, (mode_q == CTL_LOOP), bits_q};
    end

    assert_drive_lines_R1: assert property (@(posedge clk) disable iff (mreset)
        (ctl_we && !ctl_wdata[CTL_LOOP_B]) |=>
        (dtr_n == !$past(ctl_wdata[CTL_DTR]) && rts_n == !$past(ctl_wdata[CTL_RTS])));

    assert_drive_aux_R2: assert property (@(posedge clk) disable iff (mreset)
        (ctl_we && !ctl_wdata[CTL_LOOP_B]) |=>
        (out1_n == !$past(ctl_wdata[CTL_OUT1]) && out2_n == !$past(ctl_wdata[CTL_OUT2])));

    assert_loop_quiet_R4: assert property (@(posedge clk) disable iff (mreset)
        (ctl_we && ctl_wdata[CTL_LOOP_B]) |=> (dtr_n && rts_n && out1_n && out2_n));

    assert_readback_R11: assert property (@(posedge clk) disable iff (mreset)
        ctl_we |=> (ctl_rdata[CTL_W-1:0] == $past(ctl_wdata[CTL_W-1:0])));
endmodule

// File: rtl/hs_line_chan.sv
module hs_line_chan
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit RISE_ONLY   = 1'b0
) (
    input  logic clk,
    input  logic mreset,
    input  logic pin_n,
    input  logic rd_clr,
    output logic level_act,
    output logic delta
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;
    logic         stable;
    logic         change;
    dlt_state_e   dlt_q, dlt_d;

    always_ff @(posedge clk or posedge mreset) begin
        if (mreset) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[MSB-1:0], pin_n};
            last_q <= sync_q[MSB];
        end
    end

    assign stable    = sync_q[MSB];
    assign level_act = ~stable;

    generate
        if (RISE_ONLY) begin : g_rise
            assign change = stable & ~last_q;
        end else begin : g_any
            assign change = stable ^ last_q;
        end
    endgenerate

    // flag state register
    always_ff @(posedge clk or posedge mreset) begin
        if (mreset) dlt_q <= DLT_CLEAR;
        else        dlt_q <= dlt_d;
    end

    always_comb begin
        dlt_d = dlt_q;
        unique case (dlt_q)
            DLT_CLEAR: if (change)            dlt_d = DLT_SET;
            DLT_SET:   if (rd_clr && !change) dlt_d = DLT_CLEAR;
            default:   dlt_d = DLT_CLEAR;
        endcase
    end

    always_comb delta = (dlt_q == DLT_SET);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (mreset)
        (delta && !rd_clr) |=> delta);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (mreset)
        (delta && rd_clr && !change) |=> !delta);

    assert_read_keep_R9: assert property (@(posedge clk) disable iff (mreset)
        (rd_clr && change) |=> delta);

    generate
        if (RISE_ONLY) begin : g_chk_rise
            assert_ri_trailing_R7: assert property (@(posedge clk) disable iff (mreset)
                $rose(delta) |-> last_q);
        end else begin : g_chk_any
            assert_any_change_R6: assert property (@(posedge clk) disable iff (mreset)
                $rose(delta) |-> $past(change));
        end
    endgenerate
endmodule

// File: rtl/modem_hs_regs.sv
module modem_hs_regs
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = HS_DATA_W
) (
    input  logic              clk,
    input  logic              mreset,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    input  logic              sts_re,
    output logic [DATA_W-1:0] sts_rdata,
    input  logic              ms_irq_en,
    output logic              ms_irq,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n
);
    localparam int LINES = HS_LINES;

    logic [LINES-1:0] pins_n;
    logic [LINES-1:0] level;
    logic [LINES-1:0] delta;

    assign pins_n = {dcd_n, ri_n, dsr_n, cts_n};

    hs_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .mreset    (mreset),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .dtr_n     (dtr_n),
        .rts_n     (rts_n),
        .out1_n    (out1_n),
        .out2_n    (out2_n)
    );

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            hs_line_chan #(
                .SYNC_STAGES (SYNC_STAGES),
                .RISE_ONLY   (i == LINE_RI)
            ) u_chan (
                .clk       (clk),
                .mreset    (mreset),
                .pin_n     (pins_n[i]),
                .rd_clr    (sts_re),
                .level_act (level[i]),
                .delta     (delta[i])
            );
        end
    endgenerate

    always_comb begin
        sts_rdata = '0;
        sts_rdata[2*LINES-1:0] = {level, delta};
        ms_irq = ms_irq_en && (|delta);
    end

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (mreset)
        !ms_irq_en |-> !ms_irq);

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (mreset)
        (ms_irq && !sts_re && ms_irq_en) |=> (ms_irq || !ms_irq_en));

    assert_irq_flags_R10: assert property (@(posedge clk) disable iff (mreset)
        ms_irq |-> (sts_rdata[LINES-1:0] != '0));
endmodule

// File: tb/modem_hs_regs_tb.sv
module modem_hs_regs_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 9;

    // {write data, expected {out2_n,out1_n,rts_n,dtr_n}, expected read-back}
    localparam logic [19:0] VEC [NVEC] = '{
        {8'h00, 4'b1111, 8'h00},
        {8'h01, 4'b1110, 8'h01},
        {8'h02, 4'b1101, 8'h02},
        {8'h04, 4'b1011, 8'h04},
        {8'h08, 4'b0111, 8'h08},
        {8'h0F, 4'b0000, 8'h0F},
        {8'hE5, 4'b1010, 8'h05},
        {8'h1F, 4'b1111, 8'h1F},
        {8'h0A, 4'b0101, 8'h0A}
    };

    logic clk = 1'b0;
    logic mreset = 1'b1;
    logic ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic sts_re = 1'b0;
    logic [7:0] sts_rdata;
    logic ms_irq_en = 1'b0;
    logic ms_irq;
    logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic dtr_n, rts_n, out1_n, out2_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_hs_regs dut_i (
        .clk(clk), .mreset(mreset), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_re(sts_re), .sts_rdata(sts_rdata),
        .ms_irq_en(ms_irq_en), .ms_irq(ms_irq), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n),
        .out1_n(out1_n), .out2_n(out2_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0; #1;
    endtask

    task automatic rd_sts(output logic [7:0] v);
        @(negedge clk); sts_re = 1'b1; #1 v = sts_rdata;
        @(negedge clk); sts_re = 1'b0; #1;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
        #1;
    endtask

    function automatic logic [7:0] pins_out();
        return {4'b0, out2_n, out1_n, rts_n, dtr_n};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_neg(3);
        // R3: state under reset
        chk("R3 outputs in reset", pins_out(), 8'h0F);
        chk("R3 readback in reset", ctl_rdata, 8'h00);
        chk("R3 status in reset", sts_rdata, 8'h00);
        chk("R3 irq in reset", {7'b0, ms_irq}, 8'h00);
        @(negedge clk); mreset = 1'b0;
        wait_neg(2);

        // R1 R2 R4 R11: vector table walk
        for (int i = 0; i < NVEC; i++) begin
            wr_ctl(VEC[i][19:12]);
            chk("R1/R2/R4 pins", pins_out(), {4'b0, VEC[i][11:8]});
            chk("R11 readback", ctl_rdata, VEC[i][7:0]);
        end

        // R4: leave loop restores stored bits
        wr_ctl(8'h1C);
        chk("R4 loop forces high", pins_out(), 8'h0F);
        wr_ctl(8'h0C);
        chk("R4 loop cleared", pins_out(), 8'h03);

        // R3: master reset mid-operation
        wr_ctl(8'h0F);
        @(negedge clk); mreset = 1'b1; #1;
        chk("R3 reset clears outputs", pins_out(), 8'h0F);
        chk("R3 reset clears control", ctl_rdata, 8'h00);
        @(negedge clk); mreset = 1'b0;

        // R5 R6 R10: clear-to-send change
        ms_irq_en = 1'b1;
        @(negedge clk); cts_n = 1'b0;
        wait_neg(2);
        chk("R5 level after two edges", sts_rdata, 8'h10);
        wait_neg(1);
        chk("R6 cts flag after three edges", sts_rdata, 8'h11);
        chk("R10 irq raised", {7'b0, ms_irq}, 8'h01);
        wait_neg(4);
        chk("R8 flag holds without read", sts_rdata, 8'h11);
        ms_irq_en = 1'b0; #1;
        chk("R10 irq masked", {7'b0, ms_irq}, 8'h00);
        ms_irq_en = 1'b1; #1;
        rd_sts(v);
        chk("R8 read shows flag", v, 8'h11);
        chk("R8 read clears flag", sts_rdata, 8'h10);
        chk("R10 irq drops after read", {7'b0, ms_irq}, 8'h00);

        // R7: ring leading edge ignored, trailing edge flagged
        @(negedge clk); ri_n = 1'b0;
        wait_neg(4);
        chk("R7 ring leading edge no flag", sts_rdata, 8'h50);
        @(negedge clk); ri_n = 1'b1;
        wait_neg(4);
        chk("R7 ring trailing edge flag", sts_rdata, 8'h14);
        rd_sts(v);
        chk("R7 ring read", v, 8'h14);

        // R6: set-ready and carrier together
        @(negedge clk); dsr_n = 1'b0; dcd_n = 1'b0;
        wait_neg(4);
        rd_sts(v);
        chk("R6 dsr and dcd flags", v, 8'hBA);
        chk("R8 both cleared", sts_rdata, 8'hB0);

        // R9: change detected during the read cycle
        @(negedge clk); dsr_n = 1'b1;
        wait_neg(4);
        chk("R6 dsr release flag", sts_rdata, 8'h92);
        @(negedge clk); cts_n = 1'b1; dsr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); sts_re = 1'b1; #1 v = sts_rdata;
        @(negedge clk); sts_re = 1'b0; #1;
        chk("R9 read value in collision cycle", v, 8'hA2);
        chk("R9 flags kept after collision read", sts_rdata, 8'hA3);
        rd_sts(v);
        chk("R9 flags reported next read", v, 8'hA3);
        chk("R8 cleared after second read", sts_rdata, 8'hA0);

        // R3: reset clears pending flags
        @(negedge clk); dsr_n = 1'b1; dcd_n = 1'b1;
        wait_neg(4);
        @(negedge clk); mreset = 1'b1; #1;
        chk("R3 reset clears flags", sts_rdata, 8'h00);
        chk("R3 reset clears irq", {7'b0, ms_irq}, 8'h00);
        @(negedge clk); mreset = 1'b0;
        wait_neg(4);
        chk("R3 no flag after reset release", sts_rdata, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule